// File: doc/BRIEF.md
# Touch Panel Mode Transition Sequencer

This block owns the operating mode of a resistive touch-panel front end. A host register decoder hands it a one-cycle write pulse with a two-bit mode value. The block keeps the current mode, which is power-down, direct conversion or autonomous conversion. It decides whether the panel is driven and when touch sensing may be trusted.

Whenever a normal mode is commanded, the block first runs a settling sequence of two timed phases. The first phase lets the panel pull-up rise and the second lets it fall. Only after both phases does it enable touch detection. A command that moves between the normal modes also pulses an interrupt-clear strobe. A command that swaps between direct and autonomous conversion also pulses a sample-buffer clear strobe. A command issued while a sequence is still running restarts the sequence from its first phase with the new target.

Top module: `touch_mode_seq`

## Requirements
- R1: After reset the mode output is 0 (power-down) and the phase output is 0. `panel_drive_en`, `touch_det_en`, `irq_clr` and `buf_clr` are all low.
- R2: Mode code 0 is power-down. An accepted command with code 0 sets the mode to 0 and the phase to 0 on the next cycle, and drives `panel_drive_en` and `touch_det_en` low. It raises neither strobe. While the mode is 0, neither enable is ever high.
- R3: Mode code 1 is direct conversion and code 2 is autonomous conversion. Code 3 is reserved. A write carrying code 3 changes no output at all.
- R4: Take a command with code 1 or 2 sampled at clock edge E0. The phase output is 1 (rise) for RISE_CYC cycles starting right after E0. It is then 2 (fall) for FALL_CYC cycles. It then stays at 3 (settled). `panel_drive_en` is high from the cycle after E0.
- R5: `touch_det_en` is low throughout both settling phases. It goes high exactly one cycle after the phase output first shows 3, and it stays high while the mode is unchanged.
- R6: A command with code 1 or 2 issued while the current mode is 1 or 2 pulses `irq_clr` high for exactly the one cycle after the command edge. Leaving power-down does not pulse it.
- R7: `buf_clr` pulses high for exactly the one cycle after the command edge, and only when the mode changes from 2 to 1 or from 1 to 2.
- R8: A command with code 1 or 2 that arrives during the rise or the fall phase restarts the sequence at phase 1 with a full RISE_CYC count toward the new mode. A code 0 command during settling ends the sequence at once.
- R9: A command that selects the normal mode already active counts as a transition. It pulses `irq_clr` and reruns the full settling sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_wr | input | 1 | One-cycle mode write pulse |
| mode_val | input | 2 | Requested mode code (0 off, 1 direct, 2 autonomous, 3 reserved) |
| mode_o | output | 2 | Current mode code |
| settle_phase | output | 2 | Sequence phase (0 idle, 1 rise, 2 fall, 3 settled) |
| panel_drive_en | output | 1 | Panel drive enable |
| touch_det_en | output | 1 | Touch detection enable |
| irq_clr | output | 1 | One-cycle pending-interrupt clear |
| buf_clr | output | 1 | One-cycle sample-buffer clear |

## Verification
The assertions assume that `mode_wr` is a clean decoded pulse. They also assume that `mode_val` is steady in the cycle it is sampled. Reset is held for at least one clock edge before any command. The stimulus drives every write on the falling edge and holds it for exactly one cycle. Between commands it waits either a fixed few cycles, to hit a chosen settling phase, or long enough for the sequence to finish. The sweep covers every ordered pair of starting mode and commanded code, with restarts placed deliberately inside the rise and fall phases.

// File: rtl/tms_pkg.sv
package tms_pkg;
  typedef enum logic [1:0] {
    MD_OFF    = 2'd0,
    MD_DIRECT = 2'd1,
    MD_AUTO   = 2'd2,
    MD_RSVD   = 2'd3
  } mode_e;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_RISE = 2'd1,
    PH_FALL = 2'd2,
    PH_LIVE = 2'd3
  } phase_e;
endpackage

// File: rtl/tms_cmd_decode.sv
module tms_cmd_decode
  import tms_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       wr,
  input  logic [1:0] val,
  output logic       accept,
  output logic       start,
  output logic       stop,
  output mode_e      mode_q,
  output logic       irq_clr_q,
  output logic       buf_clr_q
);
  mode_e tgt;
  logic  swap;
  logic  irq_d;
  logic  buf_d;

  always_comb begin
    tgt    = mode_e'(val);
    accept = wr && (tgt != MD_RSVD);
    start  = accept && (tgt != MD_OFF);
    stop   = accept && (tgt == MD_OFF);
    swap   = ((mode_q == MD_AUTO) && (tgt == MD_DIRECT)) ||
             ((mode_q == MD_DIRECT) && (tgt == MD_AUTO));
    irq_d  = start && (mode_q != MD_OFF);
    buf_d  = start && swap;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q    <= MD_OFF;
      irq_clr_q <= 1'b0;
      buf_clr_q <= 1'b0;
    end else begin
      if (accept) mode_q <= tgt;
      irq_clr_q <= irq_d;
      buf_clr_q <= buf_d;
    end
  end

  // R6: an interrupt clear follows only from a write
  assert_irq_from_write_R6: assert property (@(posedge clk) disable iff (rst)
    irq_clr_q |-> $past(wr)) else $error("irq_clr without write");

  // R7: buffer clear only after a direct/auto swap command
  assert_buf_from_swap_R7: assert property (@(posedge clk) disable iff (rst)
    buf_clr_q |-> ($past(wr) && ($past(mode_q) != mode_q) && (mode_q != MD_OFF)))
    else $error("buf_clr without swap");

  // R3: reserved code leaves mode unchanged
  assert_rsvd_ignored_R3: assert property (@(posedge clk) disable iff (rst)
    (wr && val == 2'd3) |=> $stable(mode_q)) else $error("reserved code changed mode");
endmodule

// File: rtl/tms_settle_timer.sv
module tms_settle_timer
  import tms_pkg::*;
#(
  parameter int RISE_CYC = 8,
  parameter int FALL_CYC = 5
) (
  input  logic   clk,
  input  logic   rst,
  input  logic   start,
  input  logic   stop,
  output phase_e phase_q,
  output logic   live
);
  localparam int MAX_C = (RISE_CYC > FALL_CYC) ? RISE_CYC : FALL_CYC;
  localparam int CNT_W = $clog2(MAX_C + 1);
  localparam logic [CNT_W-1:0] RISE_LD = CNT_W'(RISE_CYC - 1);
  localparam logic [CNT_W-1:0] FALL_LD = CNT_W'(FALL_CYC - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  phase_e           ph_d;

  always_comb begin
    ph_d  = phase_q;
    cnt_d = cnt_q;
    if (stop) begin
      ph_d  = PH_IDLE;
      cnt_d = '0;
    end else if (start) begin
      ph_d  = PH_RISE;
      cnt_d = RISE_LD;
    end else begin
      case (phase_q)
        PH_RISE: begin
          if (cnt_q == '0) begin
            ph_d  = PH_FALL;
            cnt_d = FALL_LD;
          end else begin
            cnt_d = cnt_q - 1'b1;
          end
        end
        PH_FALL: begin
          if (cnt_q == '0) ph_d = PH_LIVE;
          else             cnt_d = cnt_q - 1'b1;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
    end else begin
      phase_q <= ph_d;
      cnt_q   <= cnt_d;
    end
  end

  assign live = (phase_q == PH_LIVE);

  // R4: rise hands over to fall when its count expires
  assert_rise_to_fall_R4: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_RISE && cnt_q == '0 && !start && !stop) |=> phase_q == PH_FALL)
    else $error("rise did not end in fall");

  // R4: fall hands over to settled
  assert_fall_to_live_R4: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_FALL && cnt_q == '0 && !start && !stop) |=> phase_q == PH_LIVE)
    else $error("fall did not end in settled");

  // R8: any normal command restarts at rise
  assert_restart_R8: assert property (@(posedge clk) disable iff (rst)
    start |=> (phase_q == PH_RISE && cnt_q == RISE_LD)) else $error("no restart");

  // R4: count bounded
  assert_cnt_bound_R4: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= CNT_W'(MAX_C - 1)) else $error("counter out of range");
endmodule

// File: rtl/tms_out_stage.sv
module tms_out_stage
  import tms_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic accept,
  input  logic start,
  input  logic stop,
  input  logic live,
  output logic panel_drive_q,
  output logic touch_det_q
);
  logic pd_d, td_d;

  always_comb begin
    pd_d = panel_drive_q;
    if (start)     pd_d = 1'b1;
    else if (stop) pd_d = 1'b0;
    td_d = live && !accept;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      panel_drive_q <= 1'b0;
      touch_det_q   <= 1'b0;
    end else begin
      panel_drive_q <= pd_d;
      touch_det_q   <= td_d;
    end
  end

  // R5: detection only rises after the settled phase was seen
  assert_det_after_live_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(touch_det_q) |-> $past(live)) else $error("detect enabled early");

  // R5: detection implies the panel is driven
  assert_det_needs_drive_R5: assert property (@(posedge clk) disable iff (rst)
    touch_det_q |-> panel_drive_q) else $error("detect without drive");
endmodule

// File: rtl/touch_mode_seq.sv
module touch_mode_seq
  import tms_pkg::*;
#(
  parameter int RISE_CYC = 8,
  parameter int FALL_CYC = 5
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       mode_wr,
  input  logic [1:0] mode_val,
  output logic [1:0] mode_o,
  output logic [1:0] settle_phase,
  output logic       panel_drive_en,
  output logic       touch_det_en,
  output logic       irq_clr,
  output logic       buf_clr
);
  logic   accept, start, stop, live;
  mode_e  mode_q;
  phase_e phase_q;

  tms_cmd_decode u_dec (
    .clk       (clk),
    .rst       (rst),
    .wr        (mode_wr),
    .val       (mode_val),
    .accept    (accept),
    .start     (start),
    .stop      (stop),
    .mode_q    (mode_q),
    .irq_clr_q (irq_clr),
    .buf_clr_q (buf_clr)
  );

  tms_settle_timer #(
    .RISE_CYC (RISE_CYC),
    .FALL_CYC (FALL_CYC)
  ) u_tmr (
    .clk     (clk),
    .rst     (rst),
    .start   (start),
    .stop    (stop),
    .phase_q (phase_q),
    .live    (live)
  );

  tms_out_stage u_out (
    .clk           (clk),
    .rst           (rst),
    .accept        (accept),
    .start         (start),
    .stop          (stop),
    .live          (live),
    .panel_drive_q (panel_drive_en),
    .touch_det_q   (touch_det_en)
  );

  assign mode_o       = mode_q;
  assign settle_phase = phase_q;

  // R2: power-down keeps panel and detection off
  assert_off_quiet_R2: assert property (@(posedge clk) disable iff (rst)
    (mode_q == MD_OFF) |-> (!panel_drive_en && !touch_det_en && phase_q == PH_IDLE))
    else $error("activity in power-down");

  // R6: interrupt clear pulse lines up with a fresh rise phase
  assert_irq_with_rise_R6: assert property (@(posedge clk) disable iff (rst)
    irq_clr |-> (phase_q == PH_RISE)) else $error("irq_clr outside restart");
endmodule

// File: tb/touch_mode_seq_tb.sv
module touch_mode_seq_tb;
  localparam int R = 4;
  localparam int F = 3;
  localparam int W = R + F + 3;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       mode_wr = 1'b0;
  logic [1:0] mode_val = 2'd0;
  logic [1:0] mode_o, settle_phase;
  logic       panel_drive_en, touch_det_en, irq_clr, buf_clr;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  touch_mode_seq #(.RISE_CYC(R), .FALL_CYC(F)) u_dut (
    .clk(clk), .rst(rst), .mode_wr(mode_wr), .mode_val(mode_val),
    .mode_o(mode_o), .settle_phase(settle_phase),
    .panel_drive_en(panel_drive_en), .touch_det_en(touch_det_en),
    .irq_clr(irq_clr), .buf_clr(buf_clr)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 50000 && !done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: act=hung exp=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: act=%0d exp=%0d (t=%0t)", tag, act, exp, $time);
    end
  endtask

  task automatic cmd(input int v);
    @(negedge clk); mode_wr = 1'b1; mode_val = 2'(v);
    @(negedge clk); mode_wr = 1'b0;
  endtask

  task automatic goto_mode(input int m);
    cmd(m);
    repeat (R + F + 4) @(negedge clk);
  endtask

  // f: mode in effect when the command is sampled, t: commanded code
  task automatic window(input int f, input int t);
    for (int k = 1; k <= W; k++) begin
      int em, eph, epd, etd, eirq, ebuf;
      if (k > 1) @(negedge clk);
      if (t == 3) begin
        em = f; eph = (f != 0) ? 3 : 0; epd = (f != 0); etd = (f != 0);
        eirq = 0; ebuf = 0;
      end else if (t == 0) begin
        em = 0; eph = 0; epd = 0; etd = 0; eirq = 0; ebuf = 0;
      end else begin
        em = t;
        eph = (k <= R) ? 1 : (k <= R + F) ? 2 : 3;
        epd = 1;
        etd = (k >= R + F + 2);
        eirq = (k == 1 && f != 0);
        ebuf = (k == 1 && f != 0 && f != t);
      end
      chk("R3 mode", int'(mode_o), em);
      chk("R4 phase", int'(settle_phase), eph);
      chk("R2 drive", int'(panel_drive_en), epd);
      chk("R5 detect", int'(touch_det_en), etd);
      chk("R6 irq_clr", int'(irq_clr), eirq);
      chk("R7 buf_clr", int'(buf_clr), ebuf);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 mode", int'(mode_o), 0);
    chk("R1 phase", int'(settle_phase), 0);
    chk("R1 drive", int'(panel_drive_en), 0);
    chk("R1 detect", int'(touch_det_en), 0);
    chk("R1 irq_clr", int'(irq_clr), 0);
    chk("R1 buf_clr", int'(buf_clr), 0);
    rst = 1'b0;
    @(negedge clk);

    // sweep every start mode against every code (R2, R3, R4, R5, R6, R7, R9)
    for (int f = 0; f < 3; f++) begin
      for (int t = 0; t < 4; t++) begin
        goto_mode(f);
        cmd(t);
        window(f, t);
      end
    end

    // R8: restart during rise toward a different mode
    goto_mode(0);
    cmd(1);
    repeat (2) @(negedge clk);
    cmd(2);
    window(1, 2);

    // R8 and R9: restart during fall toward the same mode
    goto_mode(0);
    cmd(1);
    repeat (R + 1) @(negedge clk);
    chk("R8 in fall", int'(settle_phase), 2);
    cmd(1);
    window(1, 1);

    // R8: power-down during rise ends the sequence
    goto_mode(0);
    cmd(2);
    @(negedge clk);
    cmd(0);
    window(2, 0);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule